// File: doc/BRIEF.md
# Chained Serial DAC Write Controller

This block sits on the host side of a serial link that feeds a chain of 12-bit voltage-output converters wired output-to-input. A single handshake hands it one code per device, packed side by side on one bus. It then turns each code into a 16-bit device word: four zero pad bits come first, then the code with its most significant bit first. The words go out back to back inside one chip-select-low window, and chip select then rises so that every converter in the chain loads its new value at the same moment.

The link runs in mode 0. The serial clock rests low, and the receivers take data on its rising edge. The data line changes only after a falling edge. The high time and the low time of the serial clock are each a number of system clocks taken from configuration inputs. Two more counts set the lead time from the chip-select fall to the first rising edge, which has to cover the output delay of one chained device plus the input setup of the next, and the minimum time chip select stays high after the update. A count of zero is treated as one. All four counts are captured when a transfer is accepted.

Top module: `dac_chain_writer`

## Requirements
- R1: While reset is held and right after it, cs_n is 1, sclk is 0, mosi is 0, in_ready is 1 and done is 0.
- R2: in_ready is 1 only while no transfer is in progress. A transfer starts on a clock edge where in_valid and in_ready are both 1. Changes to in_valid or in_codes during a transfer have no effect on the bits sent.
- R3: One transfer sends exactly NUM_DEV×16 bits in one cs_n-low window. Each 16-bit device word holds four 0 bits followed by the 12-bit code, most significant bit first.
- R4: in_codes[i*12 +: 12] is the code for device i, where device 0 is nearest the host. The word for device NUM_DEV-1 is sent first and the word for device 0 is sent last.
- R5: sclk is 0 whenever cs_n is 1. mosi does not change while sclk is 1.
- R6: Every sclk high phase lasts max(cfg_high,1) clock cycles. Every sclk low phase between two rising edges lasts max(cfg_low,1) clock cycles.
- R7: From the cs_n fall to the first sclk rise, sclk is low for max(cfg_lead,1) clock cycles.
- R8: cs_n rises only after the final sclk fall, once the low phase of max(cfg_low,1) cycles has elapsed.
- R9: cs_n stays 1 for max(cfg_hold,1) cycles after it rises. Then done pulses for exactly one cycle, and in_ready is 1 in that same cycle.
- R10: The configuration counts are captured when a transfer is accepted. Changing them during a transfer does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A set of codes is offered |
| in_ready | output | 1 | Controller is idle and can take a set of codes |
| in_codes | input | NUM_DEV*CODE_W | Packed codes, device i at bits i*CODE_W |
| cfg_high | input | DIV_W | sclk high phase length in clocks (0 means 1) |
| cfg_low | input | DIV_W | sclk low phase length in clocks (0 means 1) |
| cfg_lead | input | DIV_W | cs_n fall to first sclk rise in clocks (0 means 1) |
| cfg_hold | input | HOLD_W | Minimum cs_n high time after the update (0 means 1) |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the first device |
| cs_n | output | 1 | Active-low chip select; its rise updates every converter |
| done | output | 1 | One-cycle pulse when the hold time has elapsed |

## Verification
The bench rebuilds each frame from the serial lines and compares it with a frame computed from the codes. The code patterns used are one arbitrary mixed set, all zeros against all ones against alternating bits, and a walking one. Together they would expose swapped device order, misplaced pad bits, a reversed bit order or a shift off by one. The timing counts are tried at their fastest setting, at zero, at unequal settings and at larger settings, so that a phase running one cycle short or long, or a zero count that wraps, shows up in the measured run lengths. One transfer is disturbed in mid-flight by new codes, a new valid and new counts, to show that nothing is taken up before the next idle state.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_HOLD = 3'd4
  } dcw_state_e;

endpackage

// File: rtl/dcw_timer.sv
module dcw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic             expired
);

  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W-1:0] tmr_d;
  logic             tmr_en;

  // a phase of length max(value,1) stays while the counter is non-zero
  always_comb begin
    tmr_en = load || (tmr_q != '0);
    tmr_d  = tmr_q;
    if (load) begin
      tmr_d = (value == '0) ? '0 : value - 1'b1;
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  assign expired = (tmr_q == '0);

endmodule

// File: rtl/dcw_frame_shift.sv
module dcw_frame_shift #(
  parameter int NUM_DEV = 3,
  parameter int CODE_W  = 12,
  parameter int FILL_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      shift,
  input  logic [NUM_DEV*CODE_W-1:0] codes,
  output logic                      sdo
);

  localparam int WORD_W  = FILL_W + CODE_W;
  localparam int FRAME_W = NUM_DEV * WORD_W;

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] shreg_q;
  logic [FRAME_W-1:0] shreg_d;
  logic               shreg_en;

  // device i takes word slot i; the highest slot leaves first (farthest device)
  for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_word
    assign frame[gi*WORD_W +: WORD_W] = {{FILL_W{1'b0}}, codes[gi*CODE_W +: CODE_W]};
  end

  always_comb begin
    shreg_en = load || shift;
    shreg_d  = shreg_q;
    if (load) begin
      shreg_d = frame;
    end else if (shift) begin
      shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (shreg_en) begin
      shreg_q <= shreg_d;
    end
  end

  assign sdo = shreg_q[FRAME_W-1];

  assert_load_shift_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/dcw_ctrl.sv
module dcw_ctrl
  import dcw_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int DIV_W   = 8,
  parameter int HOLD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DIV_W-1:0]  cfg_high,
  input  logic [DIV_W-1:0]  cfg_low,
  input  logic [DIV_W-1:0]  cfg_lead,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_value,
  output logic              sh_load,
  output logic              sh_shift,
  output logic              sclk,
  output logic              cs_n,
  output logic              done
);

  localparam int TMR_W = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam logic [BIT_W-1:0] FRAME_BITS = BIT_W'(FRAME_W);

  dcw_state_e        state_q, state_d;
  logic [BIT_W-1:0]  bits_q, bits_d;
  logic [DIV_W-1:0]  hi_q, lo_q;
  logic [HOLD_W-1:0] hold_q;
  logic              cfg_en;
  logic              sclk_q, cs_n_q, done_q;
  logic              done_d;
  logic              accept;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign cfg_en   = accept;

  always_comb begin
    state_d   = state_q;
    bits_d    = bits_q;
    tmr_load  = 1'b0;
    tmr_value = '0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d   = ST_LEAD;
          tmr_load  = 1'b1;
          tmr_value = TMR_W'(cfg_lead);
          sh_load   = 1'b1;
          bits_d    = FRAME_BITS;
        end
      end
      ST_LEAD: begin
        if (tmr_expired) begin
          state_d   = ST_HIGH;
          tmr_load  = 1'b1;
          tmr_value = TMR_W'(hi_q);
        end
      end
      ST_HIGH: begin
        if (tmr_expired) begin
          state_d   = ST_LOW;
          tmr_load  = 1'b1;
          tmr_value = TMR_W'(lo_q);
          sh_shift  = 1'b1;
          bits_d    = bits_q - 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (bits_q == '0) begin
            state_d   = ST_HOLD;
            tmr_value = TMR_W'(hold_q);
          end else begin
            state_d   = ST_HIGH;
            tmr_value = TMR_W'(hi_q);
          end
        end
      end
      ST_HOLD: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      sclk_q  <= (state_d == ST_HIGH);
      cs_n_q  <= (state_d == ST_IDLE) || (state_d == ST_HOLD);
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      hold_q <= '0;
    end else if (cfg_en) begin
      hi_q   <= cfg_high;
      lo_q   <= cfg_low;
      hold_q <= cfg_hold;
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_n_q;
  assign done = done_q;

  assert_sclk_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_cs_rise_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !$past(sclk)));

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !in_ready);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_ready && cs_n));

  assert_bits_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= FRAME_BITS);

endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer #(
  parameter int NUM_DEV = 3,
  parameter int CODE_W  = 12,
  parameter int FILL_W  = 4,
  parameter int DIV_W   = 8,
  parameter int HOLD_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NUM_DEV*CODE_W-1:0] in_codes,
  input  logic [DIV_W-1:0]          cfg_high,
  input  logic [DIV_W-1:0]          cfg_low,
  input  logic [DIV_W-1:0]          cfg_lead,
  input  logic [HOLD_W-1:0]         cfg_hold,
  output logic                      sclk,
  output logic                      mosi,
  output logic                      cs_n,
  output logic                      done
);

  localparam int WORD_W  = FILL_W + CODE_W;
  localparam int FRAME_W = NUM_DEV * WORD_W;
  localparam int TMR_W   = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_value;
  logic             tmr_expired;
  logic             sh_load;
  logic             sh_shift;

  dcw_ctrl #(
    .FRAME_W (FRAME_W),
    .DIV_W   (DIV_W),
    .HOLD_W  (HOLD_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .cfg_high    (cfg_high),
    .cfg_low     (cfg_low),
    .cfg_lead    (cfg_lead),
    .cfg_hold    (cfg_hold),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_value   (tmr_value),
    .sh_load     (sh_load),
    .sh_shift    (sh_shift),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .done        (done)
  );

  dcw_timer #(
    .CNT_W (TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .value   (tmr_value),
    .expired (tmr_expired)
  );

  dcw_frame_shift #(
    .NUM_DEV (NUM_DEV),
    .CODE_W  (CODE_W),
    .FILL_W  (FILL_W)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .shift (sh_shift),
    .codes (in_codes),
    .sdo   (mosi)
  );

  assert_mosi_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_mosi_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && !$past(sh_load)) |-> !mosi || $stable(mosi));

endmodule

// File: tb/sim_dac_chain_writer.sv
module sim_dac_chain_writer;

  localparam int NUM_DEV = 3;
  localparam int CODE_W  = 12;
  localparam int NBITS   = NUM_DEV * 16;

  logic                      clk;
  logic                      rst_n;
  logic                      in_valid;
  logic                      in_ready;
  logic [NUM_DEV*CODE_W-1:0] in_codes;
  logic [7:0]                cfg_high, cfg_low, cfg_lead, cfg_hold;
  logic                      sclk, mosi, cs_n, done;

  dac_chain_writer #(.NUM_DEV(NUM_DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_codes(in_codes), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_lead(cfg_lead), .cfg_hold(cfg_hold), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // monitor state
  logic        got_bits [NBITS];
  int          nbits, run, lead, last_lo, csh, done_cnt;
  int          hi_min, hi_max, lo_min, lo_max;
  int          sclk_err, mosi_err, rdy_err, rdy_at_done;
  logic        first, counting, prev_cs, prev_sclk, prev_mosi;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b0; prev_mosi = 1'b0; counting = 1'b0;
    end else begin
      if (cs_n && sclk) sclk_err++;
      if (prev_cs && !cs_n) begin
        nbits = 0; run = 1; first = 1'b1; done_cnt = 0;
        hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
        sclk_err = 0; mosi_err = 0; rdy_err = 0; lead = -1;
      end else if (!cs_n) begin
        if (sclk && !prev_sclk) begin
          if (nbits < NBITS) got_bits[nbits] = mosi;
          nbits++;
          if (first) begin lead = run; first = 1'b0; end
          else begin
            if (run < lo_min) lo_min = run;
            if (run > lo_max) lo_max = run;
          end
          run = 1;
        end else if (!sclk && prev_sclk) begin
          if (run < hi_min) hi_min = run;
          if (run > hi_max) hi_max = run;
          run = 1;
        end else begin
          run++;
        end
        if (sclk && prev_sclk && mosi != prev_mosi) mosi_err++;
      end
      if (!cs_n && in_ready) rdy_err++;
      if (!prev_cs && cs_n) begin
        last_lo = run; csh = 0; counting = 1'b1;
      end
      if (cs_n && counting) begin
        if (done) begin
          counting = 1'b0; rdy_at_done = int'(in_ready);
        end else csh++;
      end
      if (done) done_cnt++;
      prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
    end
  end

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic exp_bit(logic [NUM_DEV*CODE_W-1:0] c, int k);
    int w = k / 16;
    int p = k % 16;
    int dev = NUM_DEV - 1 - w;
    if (p < 4) return 1'b0;
    return c[dev*CODE_W + (CODE_W - 1 - (p - 4))];
  endfunction

  task automatic send(logic [NUM_DEV*CODE_W-1:0] c, int hi, int lo, int ld, int hd);
    logic rdy;
    @(negedge clk);
    in_valid = 1'b1; in_codes = c;
    cfg_high = 8'(hi); cfg_low = 8'(lo); cfg_lead = 8'(ld); cfg_hold = 8'(hd);
    forever begin
      rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify(string tag, logic [NUM_DEV*CODE_W-1:0] c, int hi, int lo, int ld, int hd);
    int bad = 0;
    check({tag, " R3 bit count"}, nbits, NBITS);
    for (int k = 0; k < NBITS; k++)
      if (got_bits[k] !== exp_bit(c, k)) bad++;
    check({tag, " R3 R4 frame bit mismatches"}, bad, 0);
    check({tag, " R6 high min"}, hi_min, eff(hi));
    check({tag, " R6 high max"}, hi_max, eff(hi));
    check({tag, " R6 low min"}, lo_min, eff(lo));
    check({tag, " R6 low max"}, lo_max, eff(lo));
    check({tag, " R7 lead"}, lead, eff(ld));
    check({tag, " R8 last low before cs rise"}, last_lo, eff(lo));
    check({tag, " R9 cs high hold"}, csh, eff(hd));
    check({tag, " R9 done pulses"}, done_cnt, 1);
    check({tag, " R9 ready at done"}, rdy_at_done, 1);
    check({tag, " R5 sclk outside window"}, sclk_err, 0);
    check({tag, " R5 mosi moved while high"}, mosi_err, 0);
    check({tag, " R2 ready during transfer"}, rdy_err, 0);
  endtask

  task automatic t_reset();
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 mosi", int'(mosi), 0);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 done", int'(done), 0);
  endtask

  task automatic t_basic();
    logic [NUM_DEV*CODE_W-1:0] c = {12'h123, 12'h9C4, 12'hABC};
    send(c, 2, 3, 4, 5); wait_done(); verify("basic", c, 2, 3, 4, 5);
  endtask

  task automatic t_patterns();
    logic [NUM_DEV*CODE_W-1:0] c = {12'h000, 12'hFFF, 12'h555};
    send(c, 1, 1, 1, 1); wait_done(); verify("patterns", c, 1, 1, 1, 1);
  endtask

  task automatic t_zero_cfg();
    logic [NUM_DEV*CODE_W-1:0] c = {12'hAAA, 12'h001, 12'h800};
    send(c, 0, 0, 0, 0); wait_done(); verify("R10 zero counts", c, 0, 0, 0, 0);
  endtask

  task automatic t_disturb();
    logic [NUM_DEV*CODE_W-1:0] c = {12'h321, 12'h0F0, 12'hE07};
    send(c, 3, 2, 2, 4);
    repeat (6) @(negedge clk);
    in_valid = 1'b1; in_codes = {12'hFFF, 12'hFFF, 12'hFFF};
    cfg_high = 8'd9; cfg_low = 8'd7; cfg_lead = 8'd1; cfg_hold = 8'd20;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    wait_done(); verify("R2 R10 disturbed", c, 3, 2, 2, 4);
  endtask

  task automatic t_walk();
    logic [NUM_DEV*CODE_W-1:0] c = {12'h400, 12'h020, 12'h001};
    send(c, 5, 1, 7, 9); wait_done(); verify("walking one", c, 5, 1, 7, 9);
  endtask

  initial begin
    in_valid = 1'b0; in_codes = '0;
    cfg_high = 8'd1; cfg_low = 8'd1; cfg_lead = 8'd1; cfg_hold = 8'd1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_patterns();
    t_zero_cfg();
    t_disturb();
    t_walk();
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule